// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status-Carrying Queue

This block receives asynchronous serial frames on a single line and hands them to a host through a small queue. The line is sampled sixteen times per bit. A frame is one low start bit, eight or nine data bits sent least significant bit first, and one stop bit. The host selects the frame width with a mode input and sets the bit rate with a divisor input.

Finished frames go into a two-entry circular queue. Each entry holds the data byte, the ninth bit, a framing-error flag and an overrun flag. The host sees the oldest entry and its flags on the output pins. A one-cycle pop strobe removes that entry. Because the flags leave with the entry, the host must read them before it pops.

When both queue entries are occupied, a finished frame waits in the receiver's holding stage, which acts as a third level. An overrun is declared only when another start bit arrives while that frame is still waiting. The waiting frame is then lost, and the overrun is reported on the next frame that reaches the queue. Dropping the enable input empties the whole receive path.

Top module: `serial_rx_queue`

## Requirements
- R1: A sample tick occurs once every `baud_div`+1 clock cycles, and one bit lasts 16 ticks. A frame is a low start bit, then 8 data bits (9 when `nine_bit`=1) sent least significant bit first, then one stop bit.
- R2: In 8-bit mode `head_bit9` is 0. In 9-bit mode the last data bit received appears on `head_bit9` and the first eight appear on `head_data`.
- R3: A high-to-low transition of `rxd` starts a reception only while `rx_en` is 1. A frame sent while `rx_en` is 0 produces no entry.
- R4: The start bit is confirmed by a majority vote of the samples taken on ticks 7, 8 and 9 after the edge was detected. If the vote reads high, the receiver returns to idle and produces no entry.
- R5: The stop bit is sampled once at mid-bit. A low value sets `head_ferr` for that entry only.
- R6: The queue holds two entries and returns them in arrival order. `rx_done` is 1 exactly when the queue is not empty. Each `rd_pop` pulse removes one entry, and a pop on an empty queue has no effect.
- R7: The framing-error flag, the overrun flag and the ninth bit are stored with each byte. They are shown together with the head entry.
- R8: A frame that finishes while both entries are occupied waits in the holding stage. It enters the queue as soon as an entry is popped.
- R9: If a start edge is detected while the queue is full and the holding stage is occupied, the held frame is discarded. The next frame written into the queue then carries `head_ovr`=1.
- R10: Driving `rx_en` to 0 empties the queue and the holding stage and returns the receiver to idle. `rx_done` is 0 from the next cycle on.
- R11: After reset, and whenever the queue is empty, `rx_done`, `head_data`, `head_bit9`, `head_ferr` and `head_ovr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; 0 flushes the receive path |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| baud_div | input | 16 | Sample tick period minus one, in clock cycles |
| rxd | input | 1 | Serial line input (idle high) |
| rd_pop | input | 1 | One-cycle strobe that removes the head entry |
| rx_done | output | 1 | Queue is not empty |
| head_data | output | 8 | Data byte of the head entry |
| head_bit9 | output | 1 | Ninth data bit of the head entry |
| head_ferr | output | 1 | Framing-error flag of the head entry |
| head_ovr | output | 1 | Overrun flag of the head entry |

## Verification
A frame reaches the queue a few cycles after the stop bit's mid-point. The delay comes from the two-stage input synchronizer, a wait of up to one tick and one cycle from the holding stage into the queue. The bench therefore checks a frame only after the whole stop bit plus sixteen more cycles have passed. The head outputs change on the clock edge after a pop, and a waiting frame enters the queue one edge after that. Pop checks are taken two falling edges after the strobe. The flush result is checked at the first falling edge after `rx_en` drops.

// File: rtl/srxq_pkg.sv
package srxq_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              bit9;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/srxq_tick.sv
module srxq_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= div;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/srxq_shift.sv
module srxq_shift
    import srxq_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      tick,
    input  logic      rxd,
    input  logic      nine_bit,
    input  logic      can_push,
    output logic      push,
    output logic      held_valid,
    output rx_entry_t held
);
    localparam int SMP_W = $clog2(OSR);
    localparam int MID   = OSR / 2;
    localparam int SH_W  = DATA_W + 1;
    localparam int BC_W  = $clog2(SH_W + 1);
    localparam logic [SMP_W-1:0] S_LO   = SMP_W'(MID - 1);
    localparam logic [SMP_W-1:0] S_MID  = SMP_W'(MID);
    localparam logic [SMP_W-1:0] S_HI   = SMP_W'(MID + 1);
    localparam logic [SMP_W-1:0] S_LAST = SMP_W'(OSR - 1);

    logic [1:0]      sync;
    logic            rx_s;
    logic            rx_prev;
    rx_state_t       state;
    logic [SMP_W-1:0] smp;
    logic [BC_W-1:0] bitcnt;
    logic [SH_W-1:0] shreg;
    logic            v_lo, v_mid;
    logic            ovr_pend;
    logic [BC_W-1:0] last_bit;
    rx_entry_t       done_entry;

    assign rx_s     = sync[1];
    assign push     = held_valid && can_push;
    assign last_bit = nine_bit ? BC_W'(DATA_W) : BC_W'(DATA_W - 1);

    always_comb begin
        done_entry.ovr  = ovr_pend;
        done_entry.ferr = ~rx_s;
        if (nine_bit) begin
            done_entry.bit9 = shreg[SH_W-1];
            done_entry.data = shreg[DATA_W-1:0];
        end else begin
            done_entry.bit9 = 1'b0;
            done_entry.data = shreg[SH_W-1:1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync    <= 2'b11;
            rx_prev <= 1'b1;
        end else begin
            sync <= {sync[0], rxd};
            if (tick) rx_prev <= rx_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state      <= RX_IDLE;
            smp        <= '0;
            bitcnt     <= '0;
            shreg      <= '0;
            v_lo       <= 1'b0;
            v_mid      <= 1'b0;
            ovr_pend   <= 1'b0;
            held_valid <= 1'b0;
            held       <= '0;
        end else begin
            if (push) held_valid <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (rx_prev && !rx_s) begin
                            state <= RX_START;
                            smp   <= '0;
                            if (held_valid && !push) begin
                                held_valid <= 1'b0;
                                ovr_pend   <= 1'b1;
                            end
                        end
                    end
                    RX_START: begin
                        smp <= smp + 1'b1;
                        if (smp == S_LO)  v_lo  <= rx_s;
                        if (smp == S_MID) v_mid <= rx_s;
                        if (smp == S_HI && vote3(v_lo, v_mid, rx_s)) begin
                            state <= RX_IDLE;
                        end
                        if (smp == S_LAST) begin
                            state  <= RX_BITS;
                            smp    <= '0;
                            bitcnt <= '0;
                        end
                    end
                    RX_BITS: begin
                        smp <= smp + 1'b1;
                        if (smp == S_MID) shreg <= {rx_s, shreg[SH_W-1:1]};
                        if (smp == S_LAST) begin
                            smp <= '0;
                            if (bitcnt == last_bit) state <= RX_STOP;
                            else bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    default: begin
                        smp <= smp + 1'b1;
                        if (smp == S_MID) begin
                            held_valid <= 1'b1;
                            held       <= done_entry;
                            ovr_pend   <= 1'b0;
                            state      <= RX_IDLE;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/srxq_fifo.sv
module srxq_fifo
    import srxq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      push,
    input  rx_entry_t wr_entry,
    input  logic      pop,
    output logic      can_push,
    output logic      not_empty,
    output rx_entry_t head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] P_LAST = PTR_W'(DEPTH - 1);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_pop;

    assign not_empty = (count != '0);
    assign do_pop    = pop && not_empty;
    assign can_push  = (count != CNT_W'(DEPTH)) || do_pop;
    assign head      = not_empty ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wr_entry;
                wr_ptr      <= (wr_ptr == P_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == P_LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import srxq_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OSR   = 16,
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              rxd,
    input  logic              rd_pop,
    output logic              rx_done,
    output logic [DATA_W-1:0] head_data,
    output logic              head_bit9,
    output logic              head_ferr,
    output logic              head_ovr
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             tick;
    logic             push, can_push, held_valid;
    rx_entry_t        held, head;
    logic [CNT_W-1:0] fifo_count;

    srxq_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(baud_div), .tick(tick)
    );

    srxq_shift #(.OSR(OSR)) u_shift (
        .clk(clk), .rst(rst), .en(rx_en), .tick(tick), .rxd(rxd),
        .nine_bit(nine_bit), .can_push(can_push), .push(push),
        .held_valid(held_valid), .held(held)
    );

    srxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .en(rx_en), .push(push), .wr_entry(held),
        .pop(rd_pop), .can_push(can_push), .not_empty(rx_done),
        .head(head), .count(fifo_count)
    );

    assign head_data = head.data;
    assign head_bit9 = head.bit9;
    assign head_ferr = head.ferr;
    assign head_ovr  = head.ovr;
endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk #(
    parameter int DEPTH = 2,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_en,
    input logic             rd_pop,
    input logic             rx_done,
    input logic [7:0]       head_data,
    input logic             head_bit9,
    input logic             head_ferr,
    input logic             head_ovr,
    input logic             held_valid,
    input logic [CNT_W-1:0] fifo_count
);
    // R10: disabling empties the queue and the holding stage
    a_r10_flush: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rx_done && !held_valid));

    // R11: empty queue shows all-zero head outputs
    a_r11_empty_zero: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> (head_data == 8'h00 && !head_bit9 && !head_ferr && !head_ovr));

    // R6: occupancy never exceeds the queue depth
    a_r6_depth: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH));

    // R6: an entry only leaves through a pop
    a_r6_keep: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rd_pop && rx_en) |=> rx_done);

    // R8: a waiting frame moves in once there is room
    a_r8_drain: assert property (@(posedge clk) disable iff (rst)
        (rx_en && held_valid && fifo_count < CNT_W'(DEPTH)) |=> !held_valid);
endmodule

bind serial_rx_queue serial_rx_queue_chk #(.DEPTH(DEPTH), .CNT_W($clog2(DEPTH+1))) u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rd_pop(rd_pop), .rx_done(rx_done),
    .head_data(head_data), .head_bit9(head_bit9), .head_ferr(head_ferr),
    .head_ovr(head_ovr), .held_valid(held_valid), .fifo_count(fifo_count)
);

// File: tb/tb_serial_rx_queue.sv
module tb_serial_rx_queue;
    localparam int BITCLK = 64; // (baud_div+1)*16 with baud_div=3

    logic        clk = 1'b0;
    logic        rst, rx_en, nine_bit, rxd, rd_pop;
    logic [15:0] baud_div;
    logic        rx_done, head_bit9, head_ferr, head_ovr;
    logic [7:0]  head_data;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    serial_rx_queue dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .nine_bit(nine_bit),
        .baud_div(baud_div), .rxd(rxd), .rd_pop(rd_pop),
        .rx_done(rx_done), .head_data(head_data), .head_bit9(head_bit9),
        .head_ferr(head_ferr), .head_ovr(head_ovr)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R1: start, data LSB first, stop
    task automatic send(input logic [8:0] val, input logic nine, input logic stop);
        rxd = 1'b0;
        wait_clk(BITCLK);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rxd = val[i];
            wait_clk(BITCLK);
        end
        rxd = stop;
        wait_clk(BITCLK);
        rxd = 1'b1;
        wait_clk(16);
    endtask

    task automatic pop;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic head_is(input string req, input logic [7:0] d, input logic b9,
                           input logic fe, input logic ov);
        check(req, "rx_done", rx_done, 1);
        check(req, "data", head_data, d);
        check(req, "bit9", head_bit9, b9);
        check(req, "ferr", head_ferr, fe);
        check(req, "ovr", head_ovr, ov);
    endtask

    task automatic t_reset;
        // R11
        check("R11", "rx_done", rx_done, 0);
        check("R11", "data", head_data, 0);
        check("R11", "bit9", head_bit9, 0);
        check("R11", "ferr", head_ferr, 0);
    endtask

    task automatic t_basic8;
        nine_bit = 1'b0;
        send(9'h1A5, 1'b0, 1'b1);
        head_is("R1", 8'hA5, 1'b0, 1'b0, 1'b0);
        pop();
        check("R6", "empty after pop", rx_done, 0);
        pop();
        check("R6", "pop on empty", rx_done, 0);
        check("R11", "data when empty", head_data, 0);
    endtask

    task automatic t_nine;
        nine_bit = 1'b1;
        send(9'h13C, 1'b1, 1'b1);
        head_is("R2", 8'h3C, 1'b1, 1'b0, 1'b0);
        pop();
        send(9'h0C3, 1'b1, 1'b1);
        head_is("R2", 8'hC3, 1'b0, 1'b0, 1'b0);
        pop();
        nine_bit = 1'b0;
    endtask

    task automatic t_ferr;
        send(9'h055, 1'b0, 1'b0);
        send(9'h066, 1'b0, 1'b1);
        head_is("R5", 8'h55, 1'b0, 1'b1, 1'b0);
        pop();
        head_is("R7", 8'h66, 1'b0, 1'b0, 1'b0);
        pop();
        check("R6", "drained", rx_done, 0);
    endtask

    task automatic t_hold;
        send(9'h011, 1'b0, 1'b1);
        send(9'h022, 1'b0, 1'b1);
        send(9'h033, 1'b0, 1'b1);
        head_is("R6", 8'h11, 1'b0, 1'b0, 1'b0);
        pop();
        head_is("R8", 8'h22, 1'b0, 1'b0, 1'b0);
        pop();
        head_is("R8", 8'h33, 1'b0, 1'b0, 1'b0);
        pop();
        check("R8", "drained", rx_done, 0);
    endtask

    task automatic t_overrun;
        send(9'h041, 1'b0, 1'b1);
        send(9'h042, 1'b0, 1'b1);
        send(9'h043, 1'b0, 1'b1);
        send(9'h044, 1'b0, 1'b1);
        head_is("R9", 8'h41, 1'b0, 1'b0, 1'b0);
        pop();
        head_is("R9", 8'h42, 1'b0, 1'b0, 1'b0);
        pop();
        head_is("R9", 8'h44, 1'b0, 1'b0, 1'b1);
        pop();
        check("R9", "drained", rx_done, 0);
    endtask

    task automatic t_disabled;
        rx_en = 1'b0;
        send(9'h07E, 1'b0, 1'b1);
        rx_en = 1'b1;
        wait_clk(BITCLK);
        check("R3", "no entry while disabled", rx_done, 0);
    endtask

    task automatic t_flush;
        send(9'h0AA, 1'b0, 1'b1);
        send(9'h0BB, 1'b0, 1'b1);
        check("R10", "filled", rx_done, 1);
        rx_en = 1'b0;
        @(negedge clk);
        check("R10", "rx_done after disable", rx_done, 0);
        rx_en = 1'b1;
        wait_clk(4);
        check("R10", "stays empty", rx_done, 0);
    endtask

    task automatic t_glitch;
        rxd = 1'b0;
        wait_clk(8);
        rxd = 1'b1;
        wait_clk(BITCLK * 12);
        check("R4", "glitch rejected", rx_done, 0);
        send(9'h05A, 1'b0, 1'b1);
        head_is("R4", 8'h5A, 1'b0, 1'b0, 1'b0);
        pop();
    endtask

    initial begin
        int cyc = 0;
        while (!finished && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rx_en = 1'b1; nine_bit = 1'b0; rxd = 1'b1;
        rd_pop = 1'b0; baud_div = 16'd3;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(BITCLK);
        t_reset();
        t_basic8();
        t_nine();
        t_ferr();
        t_hold();
        t_overrun();
        t_disabled();
        t_flush();
        t_glitch();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule